// File: doc/BRIEF.md
# Power-Down and Wake-Up Controller

This controller decides when a small microcontroller core stops and restarts. A halt strobe from the core drops the system-clock enable and marks the power-down flag. The controller runs on an always-running clock. While halted, it watches four wake sources: the external reset, the watchdog overflow, interrupt request flags and falling edges on an 8-bit port. Each port bit can be enabled for wake on its own.

A wake starts a fixed exit delay. During the delay the core clock stays off. When the delay ends the clock enable returns, and a one-cycle resume pulse carries a code. The code tells the core to continue at the next instruction, to take the interrupt vector, to perform a warm reset (program counter and stack pointer only), or to perform a full initialisation.

Two flags record how the core came back. The time-out flag is set by a watchdog overflow. The power-down flag is set by halt. Software reads them after the restart. The interrupt requests already pending when the core halts are recorded, and they cannot cause a wake.

Top module: `pwrdn_wake_ctrl`

## Requirements
- R1: After power-up reset, the clock enable is 1, the time-out and power-down flags are 0, and no resume pulse is given.
- R2: A halt strobe in the running state drops the clock enable from the next cycle on, sets the power-down flag and clears the time-out flag.
- R3: The single-clear strobe in the running state clears the power-down flag. When halt comes in the same cycle, halt takes precedence and the flag ends at 1.
- R4: While halted, a falling edge on a port bit whose wake-enable bit is 1 causes a wake with code 0 (next instruction). Edges on bits with wake-enable 0 do not wake. Inputs pass two synchroniser stages, so the wake is taken on the third clock edge after the port change.
- R5: While halted, an interrupt request flag that rose after halt causes a wake. The code is 1 (vector) if that flag's enable is 1 and the stack is not full. Otherwise the code is 0.
- R6: An interrupt request flag that is already 1 at halt entry causes no wake.
- R7: A watchdog overflow while halted causes a wake with code 2 (warm reset) and sets the time-out flag. The power-down flag is kept.
- R8: An external reset while halted takes priority over every other wake source. It gives code 3 (full initialisation) and leaves both flags unchanged.
- R9: The clock enable stays low for exactly DELAY_CYC cycles after the cycle in which the wake is taken. The resume pulse lasts one cycle, and it is high in the first cycle in which the clock enable is back at 1.
- R10: In the running state, external reset or watchdog overflow gives a resume pulse with code 3 in the next cycle, and a halt in the same cycle is dropped. The watchdog overflow also sets the time-out flag.
- R11: An external reset during the exit delay changes the pending code to 3. It does not shorten the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| ext_rst_i | input | 1 | External reset request |
| halt_i | input | 1 | Halt strobe from the core |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| wdt_clr_i | input | 1 | Single-clear command strobe |
| port_i | input | 8 | Port pins, asynchronous |
| port_wake_en_i | input | 8 | Per-bit port wake enable |
| irq_flag_i | input | IRQ_W | Interrupt request flags |
| irq_en_i | input | IRQ_W | Interrupt enables |
| stack_full_i | input | 1 | Core stack is full |
| sys_clk_en_o | output | 1 | System clock enable |
| to_flag_o | output | 1 | Time-out flag |
| pdf_flag_o | output | 1 | Power-down flag |
| resume_valid_o | output | 1 | One-cycle resume pulse |
| resume_code_o | output | 2 | 0 next, 1 vector, 2 warm, 3 init |

## Verification
The hardest case to reach is a wake source arriving at a boundary of the halt: a request that was already pending when the halt was taken, or an external reset that lands in the middle of the 1024-cycle exit delay. The stimulus raises one interrupt flag before the halt strobe. It then raises a second flag later, which must be the one that wakes the core. In a separate run it pulses the external reset about a hundred cycles into the delay. Port wakes are driven one cycle after a clock edge so that the synchroniser latency is fixed. The bench model then predicts a delay of DELAY_CYC+3 clock-enable-low cycles for a port wake and DELAY_CYC+1 for an interrupt wake.

// File: rtl/pwk_pkg.sv
`timescale 1ns/1ps
package pwk_pkg;

  typedef enum logic [1:0] {
    RES_NEXT   = 2'd0,
    RES_VECTOR = 2'd1,
    RES_WARM   = 2'd2,
    RES_INIT   = 2'd3
  } resume_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_EXIT = 2'd2
  } pstate_e;

  typedef struct packed {
    logic ext;
    logic wdt;
    logic irq;
    logic port;
  } wake_src_t;

  // Vector only when a newly raised request is enabled and the stack has room
  function automatic resume_e irq_code(input logic enabled_hit, input logic stk_full);
    return (enabled_hit && !stk_full) ? RES_VECTOR : RES_NEXT;
  endfunction

endpackage

// File: rtl/pwk_port_edge.sv
`timescale 1ns/1ps
module pwk_port_edge #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] fall_o,
  output logic         any_fall_o
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] sync_q [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= '0;
          else        sync_q[s] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= '0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_q[LAST];
  end

  assign fall_o     = prev_q & ~sync_q[LAST] & mask_i;
  assign any_fall_o = |fall_o;

  // R4: a reported fall means the synchronised level is now low
  AST_FALL_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    any_fall_o |-> ((sync_q[LAST] & mask_i) != mask_i)) else $error("fall without low level"); // R4

endmodule

// File: rtl/pwk_wake_arb.sv
`timescale 1ns/1ps
module pwk_wake_arb
  import pwk_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halted_i,
  input  logic             ext_i,
  input  logic             wdt_i,
  input  logic [IRQ_W-1:0] irq_flag_i,
  input  logic [IRQ_W-1:0] irq_en_i,
  input  logic [IRQ_W-1:0] pend_i,
  input  logic             stack_full_i,
  input  logic             port_fall_i,
  output logic             wake_o,
  output logic             wdt_hit_o,
  output resume_e          code_o
);
  logic [IRQ_W-1:0] fresh;
  wake_src_t        src;

  assign fresh = irq_flag_i & ~pend_i;

  always_comb begin
    src    = '0;
    code_o = RES_NEXT;
    if (halted_i) begin
      if (ext_i) begin
        src.ext = 1'b1;
        code_o  = RES_INIT;
      end else if (wdt_i) begin
        src.wdt = 1'b1;
        code_o  = RES_WARM;
      end else if (|fresh) begin
        src.irq = 1'b1;
        code_o  = irq_code(|(fresh & irq_en_i), stack_full_i);
      end else if (port_fall_i) begin
        src.port = 1'b1;
        code_o   = RES_NEXT;
      end
    end
  end

  assign wake_o    = |src;
  assign wdt_hit_o = src.wdt;

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src)) else $error("several wake causes"); // R8
  AST_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_i && ext_i) |-> (wake_o && code_o == RES_INIT)) else $error("ext reset lost"); // R8
  AST_PEND_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_i && !ext_i && !wdt_i && !port_fall_i && fresh == '0) |-> !wake_o) else $error("stale irq woke"); // R6

endmodule

// File: rtl/pwk_exit_timer.sv
`timescale 1ns/1ps
module pwk_exit_timer #(
  parameter int DELAY_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic active_i,
  output logic done_o
);
  localparam int CW = $clog2(DELAY_CYC);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = active_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (start_i)           cnt_q <= '0;
    else if (active_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST) else $error("exit counter overran"); // R9
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done held"); // R9

endmodule

// File: rtl/pwrdn_wake_ctrl.sv
`timescale 1ns/1ps
module pwrdn_wake_ctrl
  import pwk_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int IRQ_W     = 4,
  parameter int SYNC_STG  = 2,
  parameter int DELAY_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst_i,
  input  logic              halt_i,
  input  logic              wdt_ovf_i,
  input  logic              wdt_clr_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [PORT_W-1:0] port_wake_en_i,
  input  logic [IRQ_W-1:0]  irq_flag_i,
  input  logic [IRQ_W-1:0]  irq_en_i,
  input  logic              stack_full_i,
  output logic              sys_clk_en_o,
  output logic              to_flag_o,
  output logic              pdf_flag_o,
  output logic              resume_valid_o,
  output logic [1:0]        resume_code_o
);
  pstate_e          st_q;
  resume_e          code_q, rcode_q;
  logic [IRQ_W-1:0] pend_q;
  logic             to_q, pdf_q, rv_q;

  logic [PORT_W-1:0] port_fall;
  logic              port_any;
  logic              wake_take, wdt_wake, exit_done;
  logic              halt_take;
  resume_e           arb_code;

  pwk_port_edge #(.W(PORT_W), .STAGES(SYNC_STG)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(port_i), .mask_i(port_wake_en_i),
    .fall_o(port_fall), .any_fall_o(port_any)
  );

  pwk_wake_arb #(.IRQ_W(IRQ_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .halted_i(st_q == ST_HALT),
    .ext_i(ext_rst_i), .wdt_i(wdt_ovf_i), .irq_flag_i(irq_flag_i),
    .irq_en_i(irq_en_i), .pend_i(pend_q), .stack_full_i(stack_full_i),
    .port_fall_i(port_any), .wake_o(wake_take), .wdt_hit_o(wdt_wake),
    .code_o(arb_code)
  );

  pwk_exit_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(wake_take),
    .active_i(st_q == ST_EXIT), .done_o(exit_done)
  );

  assign halt_take = (st_q == ST_RUN) && halt_i && !ext_rst_i && !wdt_ovf_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      code_q  <= RES_NEXT;
      rcode_q <= RES_NEXT;
      pend_q  <= '0;
      to_q    <= 1'b0;
      pdf_q   <= 1'b0;
      rv_q    <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      unique case (st_q)
        ST_RUN: begin
          if (ext_rst_i) begin
            rv_q    <= 1'b1;
            rcode_q <= RES_INIT;
          end else if (wdt_ovf_i) begin
            to_q    <= 1'b1;
            rv_q    <= 1'b1;
            rcode_q <= RES_INIT;
          end else if (halt_take) begin
            st_q   <= ST_HALT;
            pdf_q  <= 1'b1;
            to_q   <= 1'b0;
            pend_q <= irq_flag_i;
          end else if (wdt_clr_i) begin
            pdf_q <= 1'b0;
          end
        end
        ST_HALT: begin
          if (wake_take) begin
            st_q   <= ST_EXIT;
            code_q <= arb_code;
            if (wdt_wake) to_q <= 1'b1;
          end
        end
        ST_EXIT: begin
          if (ext_rst_i) code_q <= RES_INIT;
          if (exit_done) begin
            st_q    <= ST_RUN;
            rv_q    <= 1'b1;
            rcode_q <= ext_rst_i ? RES_INIT : code_q;
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign sys_clk_en_o   = (st_q == ST_RUN);
  assign to_flag_o      = to_q;
  assign pdf_flag_o     = pdf_q;
  assign resume_valid_o = rv_q;
  assign resume_code_o  = rcode_q;

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_take |=> (!sys_clk_en_o && pdf_flag_o && !to_flag_o)) else $error("halt entry wrong"); // R2
  AST_WAKE_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    wake_take |=> !sys_clk_en_o) else $error("clock back too early"); // R9
  AST_RESUME_WITH_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid_o |-> sys_clk_en_o) else $error("resume while gated"); // R9
  AST_CLK_BACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_clk_en_o) |-> resume_valid_o) else $error("clock back without resume"); // R9
  AST_WDT_SETS_TO: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_wake |=> to_flag_o) else $error("time-out flag missed"); // R7
  AST_EXT_IN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXIT && ext_rst_i) |=> (code_q == RES_INIT)) else $error("ext in exit lost"); // R11

endmodule

// File: tb/pwrdn_wake_ctrl_bench.sv
`timescale 1ns/1ps
module pwrdn_wake_ctrl_bench;
  localparam int DLY = 1024;
  localparam int IW  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_rst_i = 0, halt_i = 0, wdt_ovf_i = 0, wdt_clr_i = 0, stack_full_i = 0;
  logic [7:0] port_i = 8'hFF, port_wake_en_i = 8'h01;
  logic [IW-1:0] irq_flag_i = '0, irq_en_i = '0;
  logic sys_clk_en_o, to_flag_o, pdf_flag_o, resume_valid_o;
  logic [1:0] resume_code_o;

  pwrdn_wake_ctrl #(.IRQ_W(IW), .DELAY_CYC(DLY)) u_pwrdn_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst_i), .halt_i(halt_i),
    .wdt_ovf_i(wdt_ovf_i), .wdt_clr_i(wdt_clr_i), .port_i(port_i),
    .port_wake_en_i(port_wake_en_i), .irq_flag_i(irq_flag_i), .irq_en_i(irq_en_i),
    .stack_full_i(stack_full_i), .sys_clk_en_o(sys_clk_en_o), .to_flag_o(to_flag_o),
    .pdf_flag_o(pdf_flag_o), .resume_valid_o(resume_valid_o), .resume_code_o(resume_code_o)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: mode 0 running, 1 halted, 2 exiting
  int mode, cnt, pend_code, out_code;
  bit m_to, m_pdf, m_rv;
  logic [IW-1:0] m_pend;
  logic [7:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; cnt = 0; pend_code = 0; out_code = 0;
      m_to = 0; m_pdf = 0; m_rv = 0; m_pend = '0;
      hist = {8'h00, 8'h00, 8'h00};
    end else begin
      logic [7:0] fall;
      logic [IW-1:0] fresh;
      fall  = hist[0] & ~hist[1] & port_wake_en_i;
      fresh = irq_flag_i & ~m_pend;
      hist.push_back(port_i);
      void'(hist.pop_front());
      m_rv = 0;
      if (mode == 0) begin
        if (ext_rst_i) begin m_rv = 1; out_code = 3; end
        else if (wdt_ovf_i) begin m_to = 1; m_rv = 1; out_code = 3; end
        else if (halt_i) begin mode = 1; m_pdf = 1; m_to = 0; m_pend = irq_flag_i; end
        else if (wdt_clr_i) m_pdf = 0;
      end else if (mode == 1) begin
        bit w;
        w = 1;
        if (ext_rst_i) pend_code = 3;
        else if (wdt_ovf_i) begin pend_code = 2; m_to = 1; end
        else if (fresh != 0) pend_code = ((fresh & irq_en_i) != 0 && !stack_full_i) ? 1 : 0;
        else if (fall != 0) pend_code = 0;
        else w = 0;
        if (w) begin mode = 2; cnt = 0; end
      end else begin
        if (ext_rst_i) pend_code = 3;
        if (cnt == DLY - 1) begin mode = 0; m_rv = 1; out_code = pend_code; end
        else cnt++;
      end
    end
  end

  int last_code = -1;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R9 clk_en", sys_clk_en_o, mode == 0);
      chk("R3 pdf", pdf_flag_o, m_pdf);
      chk("R7 to", to_flag_o, m_to);
      chk("R9 resume_valid", resume_valid_o, m_rv);
      if (m_rv) chk("R5 resume_code", resume_code_o, out_code);
      if (resume_valid_o) last_code = resume_code_o;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_back(output int lows);
    int g;
    lows = 0; g = 0;
    do begin
      @(negedge clk);
      if (!sys_clk_en_o) lows++;
      g++;
    end while (!sys_clk_en_o && g < 5000);
    tick(1);
  endtask

  task automatic do_halt();
    halt_i = 1; tick(1); halt_i = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    int lows;
    tick(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 clk_en", sys_clk_en_o, 1);
    chk("R1 to", to_flag_o, 0);
    chk("R1 pdf", pdf_flag_o, 0);
    chk("R1 resume_valid", resume_valid_o, 0);
    tick(4);

    // Port wake, masked bit ignored
    do_halt();
    tick(3);
    @(negedge clk);
    chk("R2 clk_en low", sys_clk_en_o, 0);
    chk("R2 pdf", pdf_flag_o, 1);
    chk("R2 to", to_flag_o, 0);
    tick(1);
    port_i = 8'hFD;
    tick(10);
    @(negedge clk);
    chk("R4 masked bit no wake", sys_clk_en_o, 0);
    tick(1);
    port_i = 8'hFC;
    wait_back(lows);
    chk("R9 port wake delay", lows, DLY + 3);
    chk("R4 port code", last_code, 0);
    port_i = 8'hFF;
    tick(2);

    // Clear command
    wdt_clr_i = 1; tick(1); wdt_clr_i = 0;
    @(negedge clk);
    chk("R3 clear pdf", pdf_flag_o, 0);
    tick(2);

    // Pending request at halt; fresh enabled request wakes with vector
    irq_en_i = 4'hF; irq_flag_i = 4'b0010;
    tick(1);
    do_halt();
    tick(20);
    @(negedge clk);
    chk("R6 pending no wake", sys_clk_en_o, 0);
    tick(1);
    irq_flag_i = 4'b0110;
    wait_back(lows);
    chk("R9 irq wake delay", lows, DLY + 1);
    chk("R5 vector", last_code, 1);
    irq_flag_i = '0;
    tick(2);

    // Disabled request
    irq_en_i = 4'b1110;
    do_halt();
    tick(5);
    irq_flag_i = 4'b0001;
    wait_back(lows);
    chk("R5 disabled next", last_code, 0);
    irq_flag_i = '0; irq_en_i = 4'hF;
    tick(2);

    // Stack full
    stack_full_i = 1;
    do_halt();
    tick(5);
    irq_flag_i = 4'b1000;
    wait_back(lows);
    chk("R5 stack full next", last_code, 0);
    irq_flag_i = '0; stack_full_i = 0;
    tick(2);

    // Watchdog wake
    do_halt();
    tick(5);
    wdt_ovf_i = 1; tick(1); wdt_ovf_i = 0;
    wait_back(lows);
    chk("R7 warm code", last_code, 2);
    chk("R7 to set", to_flag_o, 1);
    chk("R7 pdf kept", pdf_flag_o, 1);
    tick(2);

    // External reset beats everything
    do_halt();
    tick(5);
    ext_rst_i = 1; wdt_ovf_i = 1; irq_flag_i = 4'b0100; port_i = 8'h00;
    tick(1);
    ext_rst_i = 0; wdt_ovf_i = 0; irq_flag_i = '0; port_i = 8'hFF;
    wait_back(lows);
    chk("R8 init code", last_code, 3);
    chk("R8 to unchanged", to_flag_o, 0);
    chk("R8 pdf unchanged", pdf_flag_o, 1);
    tick(3);

    // External reset inside exit delay
    do_halt();
    tick(5);
    irq_flag_i = 4'b0001; tick(1); irq_flag_i = '0;
    tick(100);
    ext_rst_i = 1; tick(1); ext_rst_i = 0;
    wait_back(lows);
    chk("R11 init after delay", last_code, 3);
    chk("R11 full delay", lows + 102, DLY + 1);
    tick(2);

    // Running-state watchdog and external reset
    wdt_ovf_i = 1; halt_i = 1; tick(1); wdt_ovf_i = 0; halt_i = 0;
    @(negedge clk);
    chk("R10 resume pulse", resume_valid_o, 1);
    chk("R10 init code", resume_code_o, 3);
    chk("R10 to set", to_flag_o, 1);
    chk("R10 halt dropped", sys_clk_en_o, 1);
    tick(2);
    ext_rst_i = 1; tick(1); ext_rst_i = 0;
    @(negedge clk);
    chk("R10 ext pulse", resume_valid_o, 1);
    chk("R10 ext code", resume_code_o, 3);
    tick(2);

    // Halt and clear together
    wdt_clr_i = 1; halt_i = 1; tick(1); wdt_clr_i = 0; halt_i = 0;
    @(negedge clk);
    chk("R3 halt beats clear", pdf_flag_o, 1);
    tick(1);
    port_i = 8'hFE;
    wait_back(lows);
    chk("R4 second port wake", last_code, 0);
    port_i = 8'hFF;
    tick(5);

    finished = 1;
    summary();
    $finish;
  end

endmodule